// File: doc/BRIEF.md
# I2C Master Byte Engine with Arbitration

This block moves one byte plus its acknowledge bit between a bus master and an I2C-style two-wire bus. A separate SCL generator supplies single-cycle strobes that mark each rising and falling SCL edge. The engine answers those strobes by driving the open-drain SDA pin, sampling the bus, and shifting bits most-significant first. START/STOP conditions and address matching belong to other blocks.

A transfer begins with a start pulse that latches the byte, the direction and, for reads, the choice between acknowledge and not-acknowledge. In transmit mode the engine compares every bit it releases with the sampled bus. If the bus reads low where the engine released it, the engine has lost arbitration. It becomes a slave receiver on the spot and stops driving, but it keeps counting the strobes until the byte ends, and it captures the winner's bits. In receive mode the engine can lose only while it is sending a not-acknowledge. A loss at that point ends the byte at once and asks the clock generator to stop.

At the end of every byte the engine raises a done flag. That flag also serves as a request to hold SCL low, and it stays up until the controlling logic writes a clear or starts the next byte.

Top module: `i2c_byte_arb`

## Requirements
- R1: After reset: `sda_oe_o`=0, `done_o`=0, `hold_scl_o`=0, `arb_lost_o`=0, `ack_rx_o`=0, `rx_byte_o`=0 and `mode_o`=0.
- R2: `sda_oe_o`=1 pulls SDA low. A start latches the transfer. In transmit mode, the cycle after a start and the cycle after each falling strobe set `sda_oe_o` to the inverse of the next data bit, taken MSB first. `sda_oe_o` changes on no other event, except for the release that ends the byte.
- R3: On each of the first eight rising strobes of a byte, the engine shifts the sampled SDA into `rx_byte_o` at bit 0, so that the first bit on the bus ends up in bit 7.
- R4: `mode_o` is encoded as 0 = master transmit, 1 = master receive and 2 = slave receive. In master transmit mode, a data bit that the engine releases but that samples low sets `arb_lost_o` and switches `mode_o` to 2. The engine then leaves SDA released for the rest of the byte and still captures the remaining bits. A driven-low bit that reads low is not a loss.
- R5: On the ninth bit in transmit or slave-receive mode, SDA is released. On the ninth rising strobe in every mode, `ack_rx_o` becomes 1 if SDA is low and 0 if it is high.
- R6: In master receive mode SDA stays released during the eight data bits. On the ninth bit the engine drives SDA low when `nack_i` was 0 at the start, and releases it when `nack_i` was 1.
- R7: In master receive mode with a not-acknowledge selected, SDA sampled low at the ninth rising strobe sets `arb_lost_o`, sets `mode_o` to 2, and raises `done_o` and `hold_scl_o` in the next cycle. The falling strobe that follows is then ignored. A low SDA during an acknowledge that the engine drives itself is not a loss.
- R8: `done_o` rises in the cycle after the falling strobe that ends the ninth bit. It stays set until `clr_i` or a start. `hold_scl_o` always equals `done_o`.
- R9: `arb_lost_o` is sticky. Only `clr_i` clears it; a start does not.
- R10: A start pulse during a byte is ignored. SCL strobes are ignored when no byte is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins a byte; ignored while a byte is in progress |
| clr_i | input | 1 | Clears the done and arbitration-lost flags |
| tx_byte_i | input | DATA_W | Byte to transmit |
| rd_mode_i | input | 1 | 1 = master receive, 0 = master transmit |
| nack_i | input | 1 | In receive mode, 1 = answer with a not-acknowledge |
| scl_rise_i | input | 1 | One-cycle strobe at an SCL rising edge |
| scl_fall_i | input | 1 | One-cycle strobe at an SCL falling edge |
| sda_in_i | input | 1 | Sampled SDA level |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| rx_byte_o | output | DATA_W | Byte shifted in from the bus |
| ack_rx_o | output | 1 | 1 = SDA was low on the ninth bit |
| arb_lost_o | output | 1 | Sticky arbitration-lost flag |
| mode_o | output | 2 | 0 master transmit, 1 master receive, 2 slave receive |
| done_o | output | 1 | Byte and acknowledge finished |
| hold_scl_o | output | 1 | Request to the SCL generator to stop clocking and hold SCL low |

## Verification
The assertions assume the following about the inputs:
- rising and falling strobes never fall in the same cycle and alternate within a byte;
- a start arrives only while SCL is low;
- at least one idle cycle separates a rising strobe from the next falling strobe, so a mode change lands before the next bit is set up.

The stimulus keeps within these limits by driving each strobe as a single-cycle pulse with two quiet cycles on either side. It changes the other device's SDA pull only just after a falling strobe, and it issues a start only once the previous byte is done, apart from the one deliberate start during a byte.

// File: rtl/iba_pkg.sv
package iba_pkg;

    typedef enum logic [1:0] {
        MODE_MTX = 2'd0,
        MODE_MRX = 2'd1,
        MODE_SRX = 2'd2
    } iba_mode_e;

    typedef struct packed {
        logic data;   // a data bit position
        logic last;   // the acknowledge position
    } iba_slot_s;

    // open-drain drive for a bit value: logic 0 pulls low
    function automatic logic pull_for(input logic bit_val);
        return ~bit_val;
    endfunction

    // drive level for the acknowledge slot of a given mode
    function automatic logic ack_pull(input iba_mode_e m, input logic nack_sel);
        return (m == MODE_MRX) ? ~nack_sel : 1'b0;
    endfunction

endpackage

// File: rtl/iba_bitctr.sv
module iba_bitctr #(
    parameter int DATA_W = 8,
    localparam int CW = $clog2(DATA_W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          adv,
    input  logic          finish,
    output logic          active,
    output logic [CW-1:0] cnt,
    output logic          last,
    output logic          pre_last
);
    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (load) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (finish) begin
            active <= 1'b0;
        end else if (adv) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign last     = (cnt == CW'(DATA_W));
    assign pre_last = (cnt == CW'(DATA_W - 1));
endmodule

// File: rtl/iba_shift.sv
module iba_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] tx_in,
    input  logic              adv,
    input  logic              cap,
    input  logic              sda,
    output logic              next_bit,
    output logic [DATA_W-1:0] rx_q
);
    logic [DATA_W-1:0] tx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            if (load)
                tx_q <= tx_in;
            else if (adv)
                tx_q <= {tx_q[DATA_W-2:0], 1'b0};
            if (cap)
                rx_q <= {rx_q[DATA_W-2:0], sda};
        end
    end

    // the bit that goes on the bus after the coming shift
    assign next_bit = tx_q[DATA_W-2];
endmodule

// File: rtl/iba_arb.sv
module iba_arb
    import iba_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  iba_mode_e load_mode,
    input  logic      clr,
    input  iba_slot_s rise_slot,
    input  logic      oe,
    input  logic      sda,
    output iba_mode_e mode,
    output logic      arb_lost,
    output logic      nack_lost
);
    logic tx_lost;

    // a released bit that reads low was overruled by another master
    assign tx_lost   = rise_slot.data & (mode == MODE_MTX) & ~oe & ~sda;
    assign nack_lost = rise_slot.last & (mode == MODE_MRX) & ~oe & ~sda;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= MODE_MTX;
            arb_lost <= 1'b0;
        end else begin
            if (load)
                mode <= load_mode;
            else if (tx_lost | nack_lost)
                mode <= MODE_SRX;

            if (tx_lost | nack_lost)
                arb_lost <= 1'b1;
            else if (clr)
                arb_lost <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_byte_arb.sv
module i2c_byte_arb
    import iba_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              clr_i,
    input  logic [DATA_W-1:0] tx_byte_i,
    input  logic              rd_mode_i,
    input  logic              nack_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              sda_in_i,
    output logic              sda_oe_o,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              ack_rx_o,
    output logic              arb_lost_o,
    output logic [1:0]        mode_o,
    output logic              done_o,
    output logic              hold_scl_o
);
    localparam int CW = $clog2(DATA_W + 1);

    logic          active, last, pre_last;
    logic [CW-1:0] cnt;
    logic          start_ok, nack_lost, next_bit, nack_lat;
    iba_slot_s     rise_slot, fall_slot;
    iba_mode_e     mode, load_mode;
    logic          finish;

    assign start_ok       = start_i & ~active;
    assign rise_slot.data = scl_rise_i & active & ~last;
    assign rise_slot.last = scl_rise_i & active & last;
    assign fall_slot.data = scl_fall_i & active & ~last;
    assign fall_slot.last = scl_fall_i & active & last;
    assign load_mode      = rd_mode_i ? MODE_MRX : MODE_MTX;
    assign finish         = fall_slot.last | nack_lost;

    iba_bitctr #(.DATA_W(DATA_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (start_ok),
        .adv      (fall_slot.data),
        .finish   (finish),
        .active   (active),
        .cnt      (cnt),
        .last     (last),
        .pre_last (pre_last)
    );

    iba_shift #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (start_ok),
        .tx_in    (tx_byte_i),
        .adv      (fall_slot.data),
        .cap      (rise_slot.data),
        .sda      (sda_in_i),
        .next_bit (next_bit),
        .rx_q     (rx_byte_o)
    );

    iba_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .load      (start_ok),
        .load_mode (load_mode),
        .clr       (clr_i),
        .rise_slot (rise_slot),
        .oe        (sda_oe_o),
        .sda       (sda_in_i),
        .mode      (mode),
        .arb_lost  (arb_lost_o),
        .nack_lost (nack_lost)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sda_oe_o <= 1'b0;
            done_o   <= 1'b0;
            ack_rx_o <= 1'b0;
            nack_lat <= 1'b0;
        end else begin
            if (start_ok) begin
                nack_lat <= nack_i;
                sda_oe_o <= rd_mode_i ? 1'b0 : pull_for(tx_byte_i[DATA_W-1]);
            end else if (fall_slot.data) begin
                if (pre_last)
                    sda_oe_o <= ack_pull(mode, nack_lat);
                else
                    sda_oe_o <= (mode == MODE_MTX) ? pull_for(next_bit) : 1'b0;
            end else if (finish) begin
                sda_oe_o <= 1'b0;
            end

            if (rise_slot.last)
                ack_rx_o <= ~sda_in_i;

            if (finish)
                done_o <= 1'b1;
            else if (clr_i | start_ok)
                done_o <= 1'b0;
        end
    end

    assign mode_o     = mode;
    assign hold_scl_o = done_o;
endmodule

// File: rtl/iba_checker.sv
module iba_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              clr_i,
    input logic              scl_fall_i,
    input logic              sda_oe_o,
    input logic [DATA_W-1:0] rx_byte_o,
    input logic              arb_lost_o,
    input logic [1:0]        mode_o,
    input logic              done_o
);
    p_sda_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !scl_fall_i && !done_o) |=> $stable(sda_oe_o) || !sda_oe_o);

    p_srx_released_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd2) |-> !sda_oe_o);

    p_loss_mode_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(arb_lost_o) |-> (mode_o == 2'd2));

    p_nack_loss_done_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(arb_lost_o) && $past(mode_o) == 2'd1) |-> done_o);

    p_rx_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> $stable(rx_byte_o));

    p_arb_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (arb_lost_o && !clr_i) |=> arb_lost_o);
endmodule

bind i2c_byte_arb iba_checker #(.DATA_W(DATA_W)) u_iba_checker (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .clr_i      (clr_i),
    .scl_fall_i (scl_fall_i),
    .sda_oe_o   (sda_oe_o),
    .rx_byte_o  (rx_byte_o),
    .arb_lost_o (arb_lost_o),
    .mode_o     (mode_o),
    .done_o     (done_o)
);

// File: tb/i2c_byte_arb_bench.sv
`timescale 1ns/1ps
module i2c_byte_arb_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0, clr = 1'b0, rd_mode = 1'b0, nack = 1'b0;
    logic       scl_rise = 1'b0, scl_fall = 1'b0, other_low = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       sda_oe, ack_rx, arb_lost, done, hold;
    logic [7:0] rx_byte;
    logic [1:0] mode;
    logic       sda_in;
    int         n_cmp = 0, n_bad = 0;
    bit         finished = 0;

    always #5 clk = ~clk;

    assign sda_in = !(sda_oe || other_low);

    i2c_byte_arb u_i2c_byte_arb (
        .clk(clk), .rst(rst), .start_i(start), .clr_i(clr),
        .tx_byte_i(tx_byte), .rd_mode_i(rd_mode), .nack_i(nack),
        .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_in_i(sda_in),
        .sda_oe_o(sda_oe), .rx_byte_o(rx_byte), .ack_rx_o(ack_rx),
        .arb_lost_o(arb_lost), .mode_o(mode), .done_o(done),
        .hold_scl_o(hold)
    );

    // behavioural reference model
    bit         m_act, m_oe, m_ack, m_arb, m_done, m_nack;
    int         m_pos, m_mode;
    logic [7:0] m_tx, m_rx;

    always @(posedge clk) begin
        if (rst) begin
            m_act = 0; m_oe = 0; m_ack = 0; m_arb = 0; m_done = 0;
            m_nack = 0; m_pos = 0; m_mode = 0; m_tx = 0; m_rx = 0;
        end else begin
            if (clr) begin m_done = 0; m_arb = 0; end
            if (start && !m_act) begin
                m_act = 1; m_pos = 0; m_tx = tx_byte; m_nack = nack;
                m_mode = rd_mode ? 1 : 0; m_done = 0;
                m_oe = rd_mode ? 1'b0 : !tx_byte[7];
            end else if (m_act && scl_rise) begin
                if (m_pos < 8) begin
                    if (m_mode == 0 && !m_oe && !sda_in) begin m_mode = 2; m_arb = 1; end
                    m_rx = {m_rx[6:0], sda_in};
                end else begin
                    m_ack = !sda_in;
                    if (m_mode == 1 && !m_oe && !sda_in) begin
                        m_arb = 1; m_mode = 2; m_done = 1; m_act = 0; m_oe = 0;
                    end
                end
            end else if (m_act && scl_fall) begin
                if (m_pos < 8) begin
                    m_pos++;
                    if (m_pos == 8) m_oe = (m_mode == 1) ? !m_nack : 1'b0;
                    else            m_oe = (m_mode == 0) ? !m_tx[7 - m_pos] : 1'b0;
                end else begin
                    m_act = 0; m_done = 1; m_oe = 0;
                end
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R2 sda_oe model", 32'(sda_oe), 32'(m_oe));
            chk("R3 rx_byte model", 32'(rx_byte), 32'(m_rx));
            chk("R5 ack_rx model", 32'(ack_rx), 32'(m_ack));
            chk("R9 arb_lost model", 32'(arb_lost), 32'(m_arb));
            chk("R4 mode model", 32'(mode), 32'(m_mode));
            chk("R8 done model", 32'(done), 32'(m_done));
            chk("R8 hold model", 32'(hold), 32'(m_done));
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic begin_byte(logic [7:0] b, logic rd, logic nk);
        tx_byte = b; rd_mode = rd; nack = nk; start = 1'b1;
        tick(1); start = 1'b0; tick(1);
    endtask

    task automatic do_rise();
        scl_rise = 1'b1; tick(1); scl_rise = 1'b0; tick(2);
    endtask

    task automatic do_fall();
        scl_fall = 1'b1; tick(1); scl_fall = 1'b0; tick(2);
    endtask

    // lowmask bit (8-i) = other device pulls SDA low on bit position i
    task automatic run_bits(logic [8:0] lowmask, int first, int count);
        for (int i = first; i < first + count; i++) begin
            other_low = lowmask[8 - i];
            tick(1);
            do_rise();
            do_fall();
        end
        other_low = 1'b0;
    endtask

    task automatic do_clear();
        clr = 1'b1; tick(1); clr = 1'b0; tick(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] lf;
        tick(3);
        rst = 1'b0;
        tick(1);
        chk("R1 reset oe", 32'(sda_oe), 0);
        chk("R1 reset done", 32'(done), 0);
        chk("R1 reset arb", 32'(arb_lost), 0);
        chk("R1 reset mode", 32'(mode), 0);
        chk("R1 reset rx", 32'(rx_byte), 0);

        // plain transmit, slave acknowledges
        begin_byte(8'hA5, 1'b0, 1'b0);
        chk("R2 first bit drive", 32'(sda_oe), 0);
        run_bits(9'b000000001, 0, 9);
        chk("R3 rx equals sent", 32'(rx_byte), 32'hA5);
        chk("R5 ack seen", 32'(ack_rx), 1);
        chk("R8 done after byte", 32'(done), 1);

        // transmit loses at bit 3 and keeps capturing
        do_clear();
        begin_byte(8'hFF, 1'b0, 1'b0);
        run_bits(9'b000110100, 0, 9);
        chk("R4 arb lost", 32'(arb_lost), 1);
        chk("R4 mode slave rx", 32'(mode), 2);
        chk("R4 winner bits", 32'(rx_byte), 32'hE5);
        chk("R5 no ack", 32'(ack_rx), 0);

        // receive with ACK; flag stays without clear
        begin_byte(8'h00, 1'b1, 1'b0);
        chk("R9 sticky over start", 32'(arb_lost), 1);
        run_bits({8'hC3, 1'b0}, 0, 8);
        chk("R6 ack drive", 32'(sda_oe), 1);
        run_bits(9'b0, 8, 1);
        chk("R6 rx data", 32'(rx_byte), 32'h3C);
        chk("R6 mode master rx", 32'(mode), 1);

        // receive with NACK overruled
        do_clear();
        chk("R9 cleared", 32'(arb_lost), 0);
        begin_byte(8'h00, 1'b1, 1'b1);
        run_bits({8'h7E, 1'b0}, 0, 8);
        chk("R6 nack released", 32'(sda_oe), 0);
        other_low = 1'b1; tick(1);
        do_rise();
        chk("R7 loss on nack", 32'(arb_lost), 1);
        chk("R7 hold at once", 32'(hold), 1);
        chk("R7 mode slave rx", 32'(mode), 2);
        do_fall();
        other_low = 1'b0;
        chk("R7 fall ignored", 32'(done), 1);

        // receive with ACK while bus low: no loss
        do_clear();
        begin_byte(8'h00, 1'b1, 1'b0);
        run_bits({8'hAA, 1'b1}, 0, 9);
        chk("R7 no loss on ack", 32'(arb_lost), 0);
        chk("R7 rx", 32'(rx_byte), 32'h55);

        // start during byte ignored; idle strobes ignored
        begin_byte(8'h0F, 1'b0, 1'b0);
        run_bits(9'b0, 0, 2);
        tx_byte = 8'hF0; start = 1'b1; tick(1); start = 1'b0; tick(1);
        run_bits(9'b0, 2, 7);
        chk("R10 busy start ignored", 32'(rx_byte), 32'h0F);
        do_rise(); do_fall();
        chk("R10 idle strobes rx", 32'(rx_byte), 32'h0F);
        chk("R10 idle strobes done", 32'(done), 1);

        // driven zeros reading low are not a loss
        begin_byte(8'h00, 1'b0, 1'b0);
        run_bits(9'b111111110, 0, 9);
        chk("R4 low on low no loss", 32'(arb_lost), 0);

        // assorted bytes
        lf = 8'h5B;
        for (int k = 0; k < 6; k++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            begin_byte(lf, 1'b0, 1'b0);
            run_bits(9'b000000001, 0, 9);
            chk("R3 assorted", 32'(rx_byte), 32'(lf));
        end

        tick(2);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule